// File: doc/BRIEF.md
# PWM Carrier Chopper

This block chops one PWM signal with a high-frequency carrier so that the result can be passed through a small isolation transformer. At the start of each active PWM phase the output gives one wide pulse. The width of that pulse is a whole number of carrier periods. After the wide pulse, the output follows a carrier with a fixed duty, set in eighths of the carrier period. While the PWM level is inactive, the output stays at its inactive level.

The carrier comes from the functional clock: a fixed divide by eight combined with a programmable prescale. Two optional inversions are available. One acts on the PWM level before modulation and the other acts on the chopped result. When the chopper is disabled, the raw PWM input passes straight through. The configuration inputs are sampled only while the PWM phase is inactive, so a pulse in progress is never disturbed.

The output is registered in every mode. An illegal prescale or pulse width is reported on an error flag, and while such a configuration is applied, the output is held at its inactive level.

Top module: `pwm_chopper`

## Requirements
- R1: After the wide first pulse, one carrier period lasts 8 × prescale clock cycles. Within each period the output is active for the first `duty` eighths, each eighth being prescale cycles long. A duty code of 0 keeps the carrier inactive.
- R2: The applied prescale and pulse width are legal only from 1 to 16 each. Otherwise `cfg_err` is 1, and while the chopper is enabled the output sits at the inactive level (equal to `inv_out`).
- R3: The first pulse is active for exactly width × 8 × prescale cycles, counted from the first cycle in which the effective PWM level is 1.
- R4: Every rising edge of the effective PWM level restarts both the carrier phase and the first pulse, so every active phase produces the same waveform.
- R5: In the cycle after the effective PWM level is 0, the output is inactive. This holds even in the middle of the first pulse or a carrier pulse.
- R6: The effective PWM level is `pwm_in` XOR the applied `inv_in`.
- R7: The modulated result is XORed with the applied `inv_out`, so the inactive output level equals `inv_out`.
- R8: With the applied enable at 0, the output equals `pwm_in` delayed by one cycle, and both inversions are ignored.
- R9: At a clock edge, the configuration inputs are captured only if the effective PWM level, computed with the currently applied `inv_in`, is 0. They take effect from the next cycle. Changes made while the level is 1 have no effect.
- R10: The output reflects the inputs with exactly one cycle of latency. After reset the output is 0, and the applied configuration is: disabled, prescale 1, width 1, duty 0, no inversions (so `cfg_err` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM level to be chopped |
| cfg_enable | input | 1 | 1 = chop, 0 = bypass |
| cfg_prescale | input | 5 | Carrier prescale, legal 1..16 |
| cfg_duty | input | 3 | Number of active eighths per carrier period |
| cfg_width | input | 5 | First-pulse width in carrier periods, legal 1..16 |
| cfg_inv_in | input | 1 | Invert PWM level before modulation |
| cfg_inv_out | input | 1 | Invert the chopped output |
| chop_out | output | 1 | Registered chopped output |
| cfg_err | output | 1 | Applied configuration is illegal |

## Verification
Bursts of different lengths are run with several prescale, duty and width settings. These show whether the divide-by-eight structure and the eighth-step duty compare are right, since a wrong prescale stretches every period while a wrong duty moves only the falling point. The extreme settings check the boundaries: prescale 16 with width 16 and duty 7, prescale 1 with width 1, and duty 0. Short bursts that end inside the first pulse, and repeated bursts, separate a correct restart and immediate drop from counters that run on from the previous phase. The remaining patterns each exercise one feature: inverted polarity, bypass, illegal values, and configuration writes while the PWM level is high. Each of these separates the capture and inversion rules from one another.

// File: rtl/chop_pkg.sv
// Package: shared widths and the configuration record of the chopper.
// Assumes duty is expressed in eighths, so the duty code is 3 bits wide.
package chop_pkg;
    localparam int PRE_W  = 5;
    localparam int DUTY_W = 3;
    localparam int WID_W  = 5;

    typedef struct packed {
        logic              en;
        logic [PRE_W-1:0]  pre;
        logic [DUTY_W-1:0] duty;
        logic [WID_W-1:0]  wid;
        logic              inv_in;
        logic              inv_out;
    } chop_cfg_t;

    localparam int CFG_W = $bits(chop_cfg_t);
endpackage

// File: rtl/chop_cfg_shadow.sv
// Holds the applied configuration. New values are captured only at an edge
// where the effective PWM level is inactive. Also reports legality.
// Assumes the configuration inputs are synchronous to clk.
module chop_cfg_shadow
    import chop_pkg::*;
#(
    parameter int MAX_PRE = 16,
    parameter int MAX_WID = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwm_in,
    input  chop_cfg_t cfg_nxt,
    output chop_cfg_t act_q,
    output logic      p_eff,
    output logic      legal
);
    localparam chop_cfg_t RST_CFG = '{en: 1'b0, pre: PRE_W'(1), duty: '0,
                                      wid: WID_W'(1), inv_in: 1'b0, inv_out: 1'b0};

    // Effective PWM level under the applied input polarity.
    always_comb p_eff = pwm_in ^ act_q.inv_in;

    // Legality of the applied prescale and width.
    always_comb legal = (act_q.pre != '0) && (int'(act_q.pre) <= MAX_PRE) &&
                        (act_q.wid != '0) && (int'(act_q.wid) <= MAX_WID);

    // Capture new configuration only while the PWM phase is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= RST_CFG;
        else if (!p_eff) act_q <= cfg_nxt;
    end
endmodule

// File: rtl/chop_carrier.sv
// Carrier generator: a prescale counter and an eighth counter. The carrier is
// active while the eighth index is below the duty code. A restart forces both
// counters to zero in the current cycle. Assumes prescale >= 1 when used.
module chop_carrier #(
    parameter int PRE_W  = 5,
    parameter int DUTY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [PRE_W-1:0]  pre,
    input  logic [DUTY_W-1:0] duty,
    output logic              carrier_hi,
    output logic              period_end
);
    logic [PRE_W-1:0]  pc_q, pc_cur;
    logic [DUTY_W-1:0] ec_q, ec_cur;
    logic              tick;

    // Current counter values, with restart taking effect in this cycle.
    always_comb begin
        pc_cur     = restart ? '0 : pc_q;
        ec_cur     = restart ? '0 : ec_q;
        tick       = (pc_cur == pre - PRE_W'(1));
        period_end = tick && (ec_cur == '1);
        carrier_hi = (ec_cur < duty);
    end

    // Advance the prescale counter and, on its wrap, the eighth counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ec_q <= '0;
        end else begin
            pc_q <= tick ? '0 : pc_cur + PRE_W'(1);
            ec_q <= tick ? ec_cur + DUTY_W'(1) : ec_cur;
        end
    end
endmodule

// File: rtl/chop_first_pulse.sv
// First-pulse timer: active from a restart until the programmed number of
// carrier periods has elapsed. Assumes width >= 1 when used.
module chop_first_pulse #(
    parameter int WID_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             period_end,
    input  logic [WID_W-1:0] wid,
    output logic             pulse_hi
);
    logic [WID_W-1:0] oc_q, oc_cur;
    logic             on_q;

    // Current period count and active flag, restart applied in this cycle.
    always_comb begin
        oc_cur   = restart ? '0 : oc_q;
        pulse_hi = restart | on_q;
    end

    // Count carrier periods and drop the pulse after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q <= '0;
            on_q <= 1'b0;
        end else if (period_end) begin
            oc_q <= oc_cur + WID_W'(1);
            on_q <= pulse_hi && (oc_cur != wid - WID_W'(1));
        end else begin
            oc_q <= oc_cur;
            on_q <= pulse_hi;
        end
    end
endmodule

// File: rtl/pwm_chopper.sv
// Top: gates the carrier and the first pulse with the effective PWM level,
// applies the output inversion, handles bypass and illegal settings, and
// registers the result. Assumes all inputs are synchronous to clk.
module pwm_chopper
    import chop_pkg::*;
#(
    parameter int MAX_PRE = 16,
    parameter int MAX_WID = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_in,
    input  logic              cfg_enable,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [DUTY_W-1:0] cfg_duty,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic              cfg_inv_in,
    input  logic              cfg_inv_out,
    output logic              chop_out,
    output logic              cfg_err
);
    chop_cfg_t cfg_nxt, act_q;
    logic      p_eff, p_d_q, cfg_legal, restart;
    logic      carrier_hi, period_end, pulse_hi, out_d;

    // Bundle the configuration inputs.
    always_comb cfg_nxt = '{en: cfg_enable, pre: cfg_prescale, duty: cfg_duty,
                            wid: cfg_width, inv_in: cfg_inv_in, inv_out: cfg_inv_out};

    chop_cfg_shadow #(.MAX_PRE(MAX_PRE), .MAX_WID(MAX_WID)) u_cfg (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cfg_nxt(cfg_nxt),
        .act_q(act_q), .p_eff(p_eff), .legal(cfg_legal));

    // Rising edge of the effective PWM level restarts all timing.
    always_comb restart = p_eff & ~p_d_q;

    chop_carrier #(.PRE_W(PRE_W), .DUTY_W(DUTY_W)) u_car (
        .clk(clk), .rst_n(rst_n), .restart(restart), .pre(act_q.pre),
        .duty(act_q.duty), .carrier_hi(carrier_hi), .period_end(period_end));

    chop_first_pulse #(.WID_W(WID_W)) u_first (
        .clk(clk), .rst_n(rst_n), .restart(restart), .period_end(period_end),
        .wid(act_q.wid), .pulse_hi(pulse_hi));

    // Select the next output level: bypass, safe level or modulated.
    always_comb begin
        if (!act_q.en)       out_d = pwm_in;
        else if (!cfg_legal) out_d = act_q.inv_out;
        else                 out_d = (p_eff & (pulse_hi | carrier_hi)) ^ act_q.inv_out;
    end

    // Register the output and the previous effective level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chop_out <= 1'b0;
            p_d_q    <= 1'b0;
        end else begin
            chop_out <= out_d;
            p_d_q    <= p_eff;
        end
    end

    // Illegal applied configuration flag.
    always_comb cfg_err = ~cfg_legal;
endmodule

// File: rtl/pwm_chopper_chk.sv
// Checker bound to pwm_chopper: timing properties of bypass, gating, first
// pulse, illegal settings and configuration hold.
module pwm_chopper_chk
    import chop_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pwm_in,
    input logic            chop_out,
    input logic [CFG_W-1:0] act_bits,
    input logic            act_en,
    input logic            act_inv_out,
    input logic            p_eff,
    input logic            p_d,
    input logic            legal
);
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> chop_out == $past(pwm_in));

    assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_en && legal && !p_eff |=> chop_out == $past(act_inv_out));

    assert_first_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_en && legal && p_eff && !p_d |=> chop_out != $past(act_inv_out));

    assert_illegal_safe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_en && !legal |=> chop_out == $past(act_inv_out));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        p_eff |=> $stable(act_bits));
endmodule

bind pwm_chopper pwm_chopper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .chop_out(chop_out),
    .act_bits(act_q), .act_en(act_q.en), .act_inv_out(act_q.inv_out),
    .p_eff(p_eff), .p_d(p_d_q), .legal(cfg_legal));

// File: tb/test_pwm_chopper.sv
`timescale 1ns/100ps
module test_pwm_chopper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [4:0] cfg_prescale = 5'd1;
    logic [2:0] cfg_duty = 3'd0;
    logic [4:0] cfg_width = 5'd1;
    logic       cfg_inv_in = 1'b0;
    logic       cfg_inv_out = 1'b0;
    logic       chop_out, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R10";
    bit done = 0;

    typedef struct { logic out; logic err; string req; } exp_t;
    exp_t q[$];

    // Bench-side model of the applied configuration.
    logic m_en = 0, m_ii = 0, m_io = 0;
    int   m_pre = 1, m_duty = 0, m_wid = 1;
    logic m_pprev = 0;
    int   m_k = 0;

    always #2.5 clk = ~clk;

    pwm_chopper i_pwm_chopper (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .cfg_enable(cfg_enable),
        .cfg_prescale(cfg_prescale), .cfg_duty(cfg_duty), .cfg_width(cfg_width),
        .cfg_inv_in(cfg_inv_in), .cfg_inv_out(cfg_inv_out),
        .chop_out(chop_out), .cfg_err(cfg_err));

    function automatic logic illegal(int pre, int wid);
        return (pre < 1) || (pre > 16) || (wid < 1) || (wid > 16);
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: drive one cycle at a negedge and push the expected result.
    task automatic cyc(input logic lvl);
        exp_t e;
        logic p, rise;
        pwm_in = lvl;
        p    = lvl ^ m_ii;
        rise = p && !m_pprev;
        m_k  = rise ? 0 : m_k + 1;
        if (!m_en)                    e.out = lvl;          // R8
        else if (illegal(m_pre, m_wid)) e.out = m_io;       // R2
        else e.out = (p && ((m_k < m_wid * 8 * m_pre) ||    // R3
                     (((m_k % (8 * m_pre)) / m_pre) < m_duty))) ^ m_io; // R1 R5 R7
        m_pprev = p;
        if (!p) begin                                        // R9
            m_en = cfg_enable; m_pre = cfg_prescale; m_duty = cfg_duty;
            m_wid = cfg_width; m_ii = cfg_inv_in; m_io = cfg_inv_out;
        end
        e.err = illegal(m_pre, m_wid);
        e.req = cur_req;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic hold(input logic lvl, input int n);
        for (int i = 0; i < n; i++) cyc(lvl);
    endtask

    task automatic setcfg(logic en, int pre, int duty, int wid, logic ii, logic io);
        cfg_enable = en; cfg_prescale = 5'(pre); cfg_duty = 3'(duty);
        cfg_width = 5'(wid); cfg_inv_in = ii; cfg_inv_out = io;
    endtask

    // Monitor: pop and compare after each active edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, chop_out, e.out, "chop_out");
            check(e.req, cfg_err, e.err, "cfg_err");
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10", chop_out, 1'b0, "reset out");
        check("R10", cfg_err, 1'b0, "reset err");

        // R8: bypass, with inversions requested but ignored
        cur_req = "R8";
        setcfg(0, 1, 4, 1, 0, 1);
        hold(0, 2); hold(1, 3); hold(0, 1); hold(1, 1); hold(0, 3);

        // R1 R3 R10: prescale 1, width 1, duty 4
        cur_req = "R1";
        setcfg(1, 1, 4, 1, 0, 0);
        hold(0, 3); hold(1, 40); hold(0, 4);

        // R1 R3: prescale 3, duty 3, width 2
        cur_req = "R3";
        setcfg(1, 3, 3, 2, 0, 0);
        hold(0, 2); hold(1, 120); hold(0, 3);

        // R1: duty 0 keeps carrier inactive after first pulse
        cur_req = "R1";
        setcfg(1, 2, 0, 1, 0, 0);
        hold(0, 2); hold(1, 40); hold(0, 2);

        // R5 R4: drops mid first pulse and repeated restarts
        cur_req = "R5";
        setcfg(1, 2, 5, 3, 0, 0);
        hold(0, 2); hold(1, 7); hold(0, 1); hold(1, 30); hold(0, 2);
        cur_req = "R4";
        hold(1, 60); hold(0, 3); hold(1, 60); hold(0, 2);

        // R6 R7: both inversions
        cur_req = "R6";
        setcfg(1, 2, 3, 1, 1, 1);
        hold(0, 1);                      // inactive under old polarity: captured
        hold(1, 3);                      // inactive under new polarity
        cur_req = "R7";
        hold(0, 50); hold(1, 4);

        // R9: change configuration while active, must be ignored
        cur_req = "R9";
        setcfg(1, 1, 6, 2, 0, 0);
        hold(0, 2); hold(1, 5);
        setcfg(1, 4, 1, 1, 0, 1);
        hold(1, 40);
        hold(0, 2); hold(1, 40); hold(0, 2);

        // R2: illegal prescale and width values
        cur_req = "R2";
        setcfg(1, 0, 4, 1, 0, 0);  hold(0, 2); hold(1, 10); hold(0, 2);
        setcfg(1, 17, 4, 1, 0, 1); hold(0, 2); hold(1, 10); hold(0, 2);
        setcfg(1, 2, 4, 0, 0, 0);  hold(0, 2); hold(1, 10); hold(0, 2);
        setcfg(1, 2, 4, 17, 0, 0); hold(0, 2); hold(1, 10); hold(0, 2);

        // R1 R3: maximum prescale and width, duty 7
        cur_req = "R3";
        setcfg(1, 16, 7, 16, 0, 0);
        hold(0, 2); hold(1, 2048 + 300); hold(0, 3);

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule